// File: doc/BRIEF.md
# Code-Change Settle and Fault-Blanking Controller

This block sits between a 5-bit voltage-select code, driven by the load while the regulator runs, and the downstream DAC. The code can move up or down in one step or in several successive steps. Its bits can also arrive with skew between them. The block synchronizes the raw bits and watches for any difference between consecutive synchronized samples. It hands a new code to the DAC only after the inputs have been quiet for a full settle window. A one-cycle strobe marks each hand-over.

Each detected difference also starts, or restarts, a much longer blanking window. The power-good and overvoltage monitors use this flag to ignore the excursions that a stepping reference causes. Both windows are parameters counted in clock cycles. The defaults are 40 cycles (400 ns) and 10000 cycles (100 us) at 100 MHz. Dropping the enable clears both windows and lets the code register follow the synchronized inputs directly.

Top module: `vid_settle_blank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `code_out` is 0 and `code_stb` and `blank_out` are low.
- R2: Take a raw code that is first sampled with a new value at rising edge n and then held, with `en` high. After edge n+SETTLE_CYC+3, `code_out` holds that value and `code_stb` is high for exactly that one cycle. The raw bits pass two synchronizer stages, and the difference is detected at edge n+2.
- R3: `code_stb` is never high in two consecutive cycles. While `en` stays high, `code_out` changes only in a cycle where `code_stb` is high.
- R4: A further change detected before capture restarts the settle window. Only one strobe follows, timed from the last detected change and carrying the final code. A code that returns to its earlier value within the window is still re-captured with a strobe.
- R5: After a single detected change at edge n+2, `blank_out` rises after that edge. It stays high for exactly BLANK_CYC cycles and falls after edge n+2+BLANK_CYC.
- R6: Every detected change restarts the blanking count. `blank_out` therefore stays high without a gap until BLANK_CYC cycles after the last detected change of a multi-step transition.
- R7: Presenting the raw code with the value it already has produces neither a strobe nor blanking, and leaves `code_out` unchanged.
- R8: At any rising edge where `en` is low, both windows are discarded. After that edge `blank_out` and `code_stb` are low, and `code_out` loads the synchronized code, so a raw value first sampled at edge n appears after edge n+2. Differences are detected only at edges where `en` is high.
- R9: `code_stb` is only ever high while `blank_out` is high. This relies on BLANK_CYC being at least SETTLE_CYC+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low clears both windows and makes the code register follow the inputs |
| code_raw | input | CODE_W | Unsynchronized voltage-select code |
| code_out | output | CODE_W | Settled code for the DAC |
| code_stb | output | 1 | One-cycle pulse when a settled code is captured |
| blank_out | output | 1 | Registered flag that masks power-good and crowbar faults |

## Verification
The assertions assume that `en` and `rst` are synchronous to `clk`. They also assume that BLANK_CYC exceeds SETTLE_CYC by at least two, which is what makes every strobe fall inside a blanking window. The bench drives every input just after a rising edge and holds each raw value for at least one full cycle, so every value reaches the synchronizer output. Values held for a single cycle appear only in the deliberate glitch case.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

  // Width of a down-counter that must hold the value n.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/vsb_sync.sv
module vsb_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/vsb_change_det.sv
module vsb_change_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         chg
);

  logic [W-1:0] d_prev;

  always_ff @(posedge clk) begin
    if (rst) d_prev <= '0;
    else     d_prev <= d;
  end

  assign chg = en && (d != d_prev);

endmodule

// File: rtl/vsb_timer.sv
module vsb_timer #(
  parameter int unsigned LEN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic busy
);

  import vsb_pkg::*;

  localparam int unsigned CW = cnt_w(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(LEN);
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CW'(1));
    end
  end

endmodule

// File: rtl/vsb_latch.sv
module vsb_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         stb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      stb <= 1'b0;
    end else if (!en) begin
      q   <= d;
      stb <= 1'b0;
    end else if (cap) begin
      q   <= d;
      stb <= 1'b1;
    end else begin
      stb <= 1'b0;
    end
  end

endmodule

// File: rtl/vid_settle_blank.sv
module vid_settle_blank #(
  parameter int          CODE_W      = 5,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 40,
  parameter int unsigned BLANK_CYC   = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] code_raw,
  output logic [CODE_W-1:0] code_out,
  output logic              code_stb,
  output logic              blank_out
);

  logic [CODE_W-1:0] code_sync;
  logic              chg;
  logic              settle_busy;
  logic              settle_prev;
  logic              settle_end;

  vsb_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (code_raw),
    .q   (code_sync)
  );

  vsb_change_det #(.W(CODE_W)) u_det (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (code_sync),
    .chg (chg)
  );

  vsb_timer #(.LEN(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .clr   (!en),
    .start (chg),
    .busy  (settle_busy)
  );

  vsb_timer #(.LEN(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst   (rst),
    .clr   (!en),
    .start (chg),
    .busy  (blank_out)
  );

  // Falling edge of the settle window marks a quiet input.
  always_ff @(posedge clk) begin
    if (rst) settle_prev <= 1'b0;
    else     settle_prev <= en && settle_busy;
  end

  assign settle_end = settle_prev && !settle_busy;

  vsb_latch #(.W(CODE_W)) u_latch (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .cap (settle_end),
    .d   (code_sync),
    .q   (code_out),
    .stb (code_stb)
  );

endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [CODE_W-1:0] code_out,
  input logic              code_stb,
  input logic              blank_out,
  input logic              chg
);

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    code_stb |=> !code_stb); // R3

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !code_stb) |-> $stable(code_out)); // R3

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!blank_out && !code_stb)); // R8

  AST_STB_BLANKED: assert property (@(posedge clk) disable iff (rst)
    code_stb |-> blank_out); // R9

  AST_BLANK_FROM_CHG: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_out) |-> $past(chg)); // R5

  AST_CHG_BLANKS: assert property (@(posedge clk) disable iff (rst)
    chg |=> blank_out); // R6

endmodule

bind vid_settle_blank vsb_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .code_out  (code_out),
  .code_stb  (code_stb),
  .blank_out (blank_out),
  .chg       (chg)
);

// File: tb/vid_settle_blank_tb.sv
module vid_settle_blank_tb;

  localparam int S = 4;
  localparam int B = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b1;
  logic [4:0] raw = 5'd0;
  logic [4:0] code_out;
  logic       code_stb;
  logic       blank_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wd = 0;
  int blank_end = -1;
  int stb_due = -1;
  logic [4:0] rh [4];
  logic [4:0] mcode = 5'd0;
  logic       prev_stb = 1'b0;
  string tag = "R1";
  string btag = "R1";

  vid_settle_blank #(.CODE_W(5), .SYNC_STAGES(2), .SETTLE_CYC(S), .BLANK_CYC(B)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .code_raw  (raw),
    .code_out  (code_out),
    .code_stb  (code_stb),
    .blank_out (blank_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", t, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic eb, es;
    @(posedge clk);
    #1;
    cyc++;
    rh[3] = rh[2]; rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = raw;
    if (rst) begin
      for (int i = 0; i < 4; i++) rh[i] = 5'd0;
      blank_end = -1; stb_due = -1; mcode = 5'd0;
      eb = 1'b0; es = 1'b0;
    end else if (!en) begin
      blank_end = -1; stb_due = -1; mcode = rh[2];
      eb = 1'b0; es = 1'b0;
    end else begin
      if (rh[2] != rh[3]) begin
        blank_end = cyc - 1 + B;
        stb_due = cyc + S + 1;
      end
      eb = (cyc <= blank_end);
      es = (cyc == stb_due);
      if (es) mcode = rh[2];
    end
    chk(tag, "code_out", int'(code_out), int'(mcode));
    chk(tag, "code_stb", int'(code_stb), int'(es));
    chk(btag, "blank_out", int'(blank_out), int'(eb));
    if (code_stb) begin
      chk("R3", "stb_twice", int'(prev_stb), 0);
      chk("R9", "stb_outside_blank", int'(blank_out), 1);
    end
    prev_stb = code_stb;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drv(input logic [4:0] v, input string t, input string bt);
    tag = t; btag = bt;
    raw = v;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) rh[i] = 5'd0;
    // R1: reset state with nonzero inputs
    raw = 5'd21;
    hold(4);
    rst = 1'b0;
    hold(1);
    raw = 5'd0;
    hold(30);

    // R2 / R5 / R7: all ordered pairs of codes, one change at a time
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        if (raw == 5'(a)) drv(5'(a), "R7", "R7"); else drv(5'(a), "R2", "R5");
        hold(30);
        if (raw == 5'(b)) drv(5'(b), "R7", "R7"); else drv(5'(b), "R2", "R5");
        hold(30);
      end
    end

    // R4: multi-step transition faster than the settle window
    for (int k = 1; k <= 5; k++) begin
      drv(5'(k * 3), "R4", "R6");
      hold(2);
    end
    hold(30);
    // R4: glitch that returns to the held value
    drv(5'd9, "R4", "R6");
    hold(1);
    drv(5'd15, "R4", "R6");
    hold(30);

    // R6: steps slower than settle but faster than blanking
    for (int k = 0; k < 6; k++) begin
      drv(5'(31 - k * 4), "R6", "R6");
      hold(10);
    end
    hold(30);

    // R8: disable mid-window, change while disabled, re-enable
    drv(5'd2, "R8", "R8");
    hold(3);
    en = 1'b0;
    hold(3);
    drv(5'd27, "R8", "R8");
    hold(5);
    drv(5'd6, "R8", "R8");
    hold(5);
    en = 1'b1;
    hold(30);
    drv(5'd13, "R8", "R8");
    hold(1);
    en = 1'b0;
    hold(2);
    en = 1'b1;
    hold(30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule